// File: doc/BRIEF.md
# Command/Data-Split Memory Port with On-Chip Backing Store

This block stands in for the user side of a DRAM controller port. It keeps the split between commands and data: the user queues commands (an opcode, a burst length and a byte address) in one FIFO and write data in a second FIFO. Read results come back through a third FIFO. All three FIFOs run on one clock. A small on-chip array takes the place of external DRAM. Commands run strictly in order, one burst beat per clock.

After reset the port reports itself uncalibrated for a fixed, parameterized number of cycles, and it drops any command offered in that window. Two sticky error flags record misuse. The first marks a write burst that found its data FIFO empty. The second marks a read word that met a full return FIFO. A read command waits at the head of the command queue until the return FIFO has room for its whole burst, so the second flag stays low under any legal use.

The block fits designs that need to exercise controller-facing logic without a memory device. Examples are built-in self-test sequencers and data movers.

Top module: `uport_ram`

## Requirements
- R1: After reset, every queue is empty, every level is 0, both error flags are 0 and `init_done` is 0. `init_done` goes to 1 on exactly the `CAL_CYCLES`-th rising edge after reset is released and then stays at 1.
- R2: A `cq_push` seen while `init_done` is 0 is dropped, and `cq_empty` stays 1.
- R3: A command enters the command queue on a clock where `cq_push` is 1, `cq_full` is 0 and `init_done` is 1. `cq_full` rises once `CMD_DEPTH` commands are waiting. A push while the queue is full is dropped.
- R4: `wq_push` with `wq_full` at 0 appends one word and its mask. `wq_level` gives the number of stored words. `wq_full` rises at `FIFO_DEPTH` words, and a push while full leaves the level unchanged.
- R5: Opcode 3'b000 (write) takes `cq_len`+1 words from the write queue. It stores them in consecutive array words, starting at word `cq_addr`/16 (address bits 3:0 are ignored) and wrapping modulo `MEM_WORDS`.
- R6: Mask bit i set to 1 keeps byte i (data bits 8i+7..8i) of the target word unchanged. A mask of 0 writes all 16 bytes.
- R7: Opcode 3'b001 (read) appends `cq_len`+1 words to the return queue in address order. `rq_data` always shows the oldest unpopped word. `rq_empty` stays 0 while any word is unpopped, and each `rq_pop` removes one word.
- R8: A read command is held at the head of the command queue until the return queue has at least `cq_len`+1 free entries. Commands behind it wait too, and `rq_lost` stays 0.
- R9: A write beat that finds the write queue empty leaves its target word unchanged and sets `wq_starved`. The flag stays at 1 until reset.
- R10: Commands execute in the order they were accepted. Each one finishes its whole burst before the next one starts.
- R11: A command with any other opcode is removed from the queue and has no effect. It consumes no write data and changes no array word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for all queues and the array |
| rst | input | 1 | Synchronous reset, active high |
| init_done | output | 1 | High once the start-up delay has elapsed |
| cq_push | input | 1 | Offer a command this cycle |
| cq_op | input | 3 | Opcode: 000 write, 001 read |
| cq_len | input | BL_W (6) | Burst length minus one |
| cq_addr | input | ADDR_W (30) | Byte address of the first word |
| cq_empty | output | 1 | No command waiting |
| cq_full | output | 1 | Command queue holds CMD_DEPTH entries |
| wq_push | input | 1 | Append one write word |
| wq_data | input | DATA_W (128) | Write word |
| wq_mask | input | DATA_W/8 (16) | Per-byte write block, 1 keeps the byte |
| wq_level | output | log2(FIFO_DEPTH)+1 (7) | Words in the write queue |
| wq_full | output | 1 | Write queue full |
| wq_empty | output | 1 | Write queue empty |
| wq_starved | output | 1 | Sticky: a write beat found no data |
| rq_pop | input | 1 | Remove the oldest return word |
| rq_data | output | DATA_W (128) | Oldest return word |
| rq_level | output | log2(FIFO_DEPTH)+1 (7) | Words in the return queue |
| rq_full | output | 1 | Return queue full |
| rq_empty | output | 1 | Return queue empty |
| rq_lost | output | 1 | Sticky: a read word met a full return queue |

## Verification
The bench builds the block with `CAL_CYCLES` set to 12, `MEM_WORDS` set to 16 and `CMD_DEPTH` set to 4, and keeps the default 64-entry data queues. The short start-up window lets every cycle of the drop-before-ready behaviour be checked. The 16-word array makes bursts wrap round the array and lets a 64-beat burst overwrite each word several times. The 4-deep command queue can be filled behind a read that is blocked by a return queue holding 63 words. A behavioural queue model runs beside the block and checks every output on every clock.

// File: rtl/uport_pkg.sv
package uport_pkg;

   localparam int OP_W = 3;
   localparam logic [OP_W-1:0] OP_STORE = 3'b000;
   localparam logic [OP_W-1:0] OP_FETCH = 3'b001;

   typedef enum logic [1:0] {
      ENG_IDLE  = 2'd0,
      ENG_STORE = 2'd1,
      ENG_FETCH = 2'd2
   } eng_state_e;

endpackage

// File: rtl/uport_fifo.sv
module uport_fifo #(
   parameter  int WIDTH = 8,
   parameter  int DEPTH = 64,
   localparam int AW    = $clog2(DEPTH),
   localparam int CW    = AW + 1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             push,
   input  logic [WIDTH-1:0] din,
   input  logic             pop,
   output logic [WIDTH-1:0] dout,
   output logic [CW-1:0]    count,
   output logic             full,
   output logic             empty
);

   if (DEPTH < 2 || (1 << AW) != DEPTH) begin : g_bad_depth
      $error("uport_fifo: DEPTH must be a power of two of at least 2");
   end

   logic [WIDTH-1:0] slots [DEPTH];
   logic [AW-1:0]    wp, rp;
   logic             do_push, do_pop;

   assign full    = (count == CW'(DEPTH));
   assign empty   = (count == '0);
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign dout    = slots[rp];

   always_ff @(posedge clk) begin
      if (rst) begin
         wp    <= '0;
         rp    <= '0;
         count <= '0;
      end else begin
         if (do_push) wp <= wp + AW'(1);
         if (do_pop)  rp <= rp + AW'(1);
         case ({do_push, do_pop})
            2'b10:   count <= count + CW'(1);
            2'b01:   count <= count - CW'(1);
            default: count <= count;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (do_push) slots[wp] <= din;
   end

endmodule

// File: rtl/uport_calgate.sv
module uport_calgate #(
   parameter  int CAL_CYCLES = 16,
   localparam int CW         = $clog2(CAL_CYCLES + 1)
) (
   input  logic clk,
   input  logic rst,
   output logic done
);

   if (CAL_CYCLES < 1) begin : g_bad_cal
      $error("uport_calgate: CAL_CYCLES must be at least 1");
   end

   logic [CW-1:0] ticks;

   always_ff @(posedge clk) begin
      if (rst) begin
         ticks <= '0;
         done  <= 1'b0;
      end else if (!done) begin
         ticks <= ticks + CW'(1);
         done  <= (ticks == CW'(CAL_CYCLES - 1));
      end
   end

endmodule

// File: rtl/uport_engine.sv
module uport_engine
   import uport_pkg::*;
#(
   parameter  int DATA_W     = 128,
   parameter  int BL_W       = 6,
   parameter  int ADDR_W     = 30,
   parameter  int MEM_WORDS  = 64,
   parameter  int FIFO_DEPTH = 64,
   localparam int MASK_W     = DATA_W / 8,
   localparam int LANE_AW    = $clog2(MASK_W),
   localparam int MEM_AW     = $clog2(MEM_WORDS),
   localparam int CNT_W      = $clog2(FIFO_DEPTH) + 1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              cmd_empty,
   input  logic [OP_W-1:0]   cmd_op,
   input  logic [BL_W-1:0]   cmd_len,
   input  logic [ADDR_W-1:0] cmd_addr,
   output logic              cmd_pop,
   input  logic              wd_empty,
   input  logic [DATA_W-1:0] wd_data,
   input  logic [MASK_W-1:0] wd_mask,
   output logic              wd_pop,
   input  logic              rd_full,
   input  logic [CNT_W-1:0]  rd_count,
   output logic              rd_push,
   output logic [DATA_W-1:0] rd_word,
   output logic              starved,
   output logic              lost
);

   if ((1 << MEM_AW) != MEM_WORDS || MEM_WORDS < 2) begin : g_bad_mem
      $error("uport_engine: MEM_WORDS must be a power of two of at least 2");
   end
   if (ADDR_W <= LANE_AW + MEM_AW) begin : g_bad_addr
      $error("uport_engine: ADDR_W too narrow for the array");
   end
   if ((1 << BL_W) > FIFO_DEPTH) begin : g_bad_burst
      $error("uport_engine: longest burst must fit in a data queue");
   end

   eng_state_e        state;
   logic [MEM_AW-1:0] ptr;
   logic [BL_W-1:0]   left;
   logic [CNT_W:0]    need;
   logic              room;
   logic [DATA_W-1:0] store [MEM_WORDS];
   logic [DATA_W-1:0] cur, merged;
   logic              unused_addr;

   assign unused_addr = ^{cmd_addr[LANE_AW-1:0], cmd_addr[ADDR_W-1:LANE_AW+MEM_AW]};

   // Free return space must cover the whole burst before a read starts.
   assign need = (CNT_W+1)'(rd_count) + (CNT_W+1)'(cmd_len) + (CNT_W+1)'(1);
   assign room = (need <= (CNT_W+1)'(FIFO_DEPTH));

   assign cmd_pop = (state == ENG_IDLE) && !cmd_empty && ((cmd_op != OP_FETCH) || room);
   assign wd_pop  = (state == ENG_STORE) && !wd_empty;
   assign rd_push = (state == ENG_FETCH);
   assign cur     = store[ptr];
   assign rd_word = cur;

   for (genvar g = 0; g < MASK_W; g++) begin : g_lane
      assign merged[g*8 +: 8] = wd_mask[g] ? cur[g*8 +: 8] : wd_data[g*8 +: 8];
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state   <= ENG_IDLE;
         ptr     <= '0;
         left    <= '0;
         starved <= 1'b0;
         lost    <= 1'b0;
      end else begin
         case (state)
            ENG_IDLE: begin
               if (cmd_pop) begin
                  ptr  <= cmd_addr[LANE_AW +: MEM_AW];
                  left <= cmd_len;
                  case (cmd_op)
                     OP_STORE: state <= ENG_STORE;
                     OP_FETCH: state <= ENG_FETCH;
                     default:  state <= ENG_IDLE;
                  endcase
               end
            end
            ENG_STORE, ENG_FETCH: begin
               if (state == ENG_STORE && wd_empty) starved <= 1'b1;
               if (state == ENG_FETCH && rd_full)  lost    <= 1'b1;
               ptr <= ptr + MEM_AW'(1);
               if (left == '0) state <= ENG_IDLE;
               else            left  <= left - BL_W'(1);
            end
            default: state <= ENG_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (wd_pop) store[ptr] <= merged;
   end

endmodule

// File: rtl/uport_ram.sv
module uport_ram
   import uport_pkg::*;
#(
   parameter  int DATA_W     = 128,
   parameter  int ADDR_W     = 30,
   parameter  int BL_W       = 6,
   parameter  int FIFO_DEPTH = 64,
   parameter  int CMD_DEPTH  = 4,
   parameter  int MEM_WORDS  = 64,
   parameter  int CAL_CYCLES = 16,
   localparam int MASK_W     = DATA_W / 8,
   localparam int CNT_W      = $clog2(FIFO_DEPTH) + 1,
   localparam int CQ_CW      = $clog2(CMD_DEPTH) + 1,
   localparam int CQ_W       = OP_W + BL_W + ADDR_W
) (
   input  logic              clk,
   input  logic              rst,
   output logic              init_done,
   input  logic              cq_push,
   input  logic [OP_W-1:0]   cq_op,
   input  logic [BL_W-1:0]   cq_len,
   input  logic [ADDR_W-1:0] cq_addr,
   output logic              cq_empty,
   output logic              cq_full,
   input  logic              wq_push,
   input  logic [DATA_W-1:0] wq_data,
   input  logic [MASK_W-1:0] wq_mask,
   output logic [CNT_W-1:0]  wq_level,
   output logic              wq_full,
   output logic              wq_empty,
   output logic              wq_starved,
   input  logic              rq_pop,
   output logic [DATA_W-1:0] rq_data,
   output logic [CNT_W-1:0]  rq_level,
   output logic              rq_full,
   output logic              rq_empty,
   output logic              rq_lost
);

   if (DATA_W % 8 != 0) begin : g_bad_data
      $error("uport_ram: DATA_W must be a whole number of bytes");
   end

   logic [CQ_W-1:0]          cq_head;
   logic [CQ_CW-1:0]         cq_level_unused;
   logic                     cmd_pop;
   logic [DATA_W+MASK_W-1:0] wq_head;
   logic                     wd_pop;
   logic                     rd_push;
   logic [DATA_W-1:0]        rd_word;

   uport_calgate #(.CAL_CYCLES(CAL_CYCLES)) u_cal (
      .clk  (clk),
      .rst  (rst),
      .done (init_done)
   );

   uport_fifo #(.WIDTH(CQ_W), .DEPTH(CMD_DEPTH)) u_cmdq (
      .clk   (clk),
      .rst   (rst),
      .push  (cq_push && init_done),
      .din   ({cq_op, cq_len, cq_addr}),
      .pop   (cmd_pop),
      .dout  (cq_head),
      .count (cq_level_unused),
      .full  (cq_full),
      .empty (cq_empty)
   );

   uport_fifo #(.WIDTH(DATA_W + MASK_W), .DEPTH(FIFO_DEPTH)) u_wrq (
      .clk   (clk),
      .rst   (rst),
      .push  (wq_push),
      .din   ({wq_mask, wq_data}),
      .pop   (wd_pop),
      .dout  (wq_head),
      .count (wq_level),
      .full  (wq_full),
      .empty (wq_empty)
   );

   uport_fifo #(.WIDTH(DATA_W), .DEPTH(FIFO_DEPTH)) u_rdq (
      .clk   (clk),
      .rst   (rst),
      .push  (rd_push),
      .din   (rd_word),
      .pop   (rq_pop),
      .dout  (rq_data),
      .count (rq_level),
      .full  (rq_full),
      .empty (rq_empty)
   );

   uport_engine #(
      .DATA_W     (DATA_W),
      .BL_W       (BL_W),
      .ADDR_W     (ADDR_W),
      .MEM_WORDS  (MEM_WORDS),
      .FIFO_DEPTH (FIFO_DEPTH)
   ) u_eng (
      .clk       (clk),
      .rst       (rst),
      .cmd_empty (cq_empty),
      .cmd_op    (cq_head[CQ_W-1 -: OP_W]),
      .cmd_len   (cq_head[ADDR_W +: BL_W]),
      .cmd_addr  (cq_head[ADDR_W-1:0]),
      .cmd_pop   (cmd_pop),
      .wd_empty  (wq_empty),
      .wd_data   (wq_head[DATA_W-1:0]),
      .wd_mask   (wq_head[DATA_W +: MASK_W]),
      .wd_pop    (wd_pop),
      .rd_full   (rq_full),
      .rd_count  (rq_level),
      .rd_push   (rd_push),
      .rd_word   (rd_word),
      .starved   (wq_starved),
      .lost      (rq_lost)
   );

endmodule

// File: rtl/uport_ram_chk.sv
module uport_ram_chk #(
   parameter  int FIFO_DEPTH = 64,
   localparam int CNT_W      = $clog2(FIFO_DEPTH) + 1
) (
   input logic             clk,
   input logic             rst,
   input logic             init_done,
   input logic             cq_empty,
   input logic             wq_full,
   input logic [CNT_W-1:0] wq_level,
   input logic             wq_starved,
   input logic             rq_lost
);

   // R1
   init_hold_chk: assert property (@(posedge clk) disable iff (rst)
      init_done |=> init_done);

   // R2
   early_cmd_chk: assert property (@(posedge clk) disable iff (rst)
      !init_done |=> cq_empty);

   // R4
   wq_full_hold_chk: assert property (@(posedge clk) disable iff (rst)
      wq_full |=> (wq_level <= $past(wq_level)));

   // R4
   wq_bound_chk: assert property (@(posedge clk) disable iff (rst)
      wq_level <= CNT_W'(FIFO_DEPTH));

   // R8
   no_lost_chk: assert property (@(posedge clk) disable iff (rst)
      !rq_lost);

   // R9
   starved_sticky_chk: assert property (@(posedge clk) disable iff (rst)
      wq_starved |=> wq_starved);

endmodule

bind uport_ram uport_ram_chk #(.FIFO_DEPTH(FIFO_DEPTH)) u_chk (
   .clk        (clk),
   .rst        (rst),
   .init_done  (init_done),
   .cq_empty   (cq_empty),
   .wq_full    (wq_full),
   .wq_level   (wq_level),
   .wq_starved (wq_starved),
   .rq_lost    (rq_lost)
);

// File: tb/uport_ram_tb.sv
module uport_ram_tb;

   localparam int CAL = 12;
   localparam int MW  = 16;
   localparam int CD  = 4;
   localparam int FD  = 64;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic         init_done;
   logic         cq_push = 1'b0;
   logic [2:0]   cq_op = '0;
   logic [5:0]   cq_len = '0;
   logic [29:0]  cq_addr = '0;
   logic         cq_empty, cq_full;
   logic         wq_push = 1'b0;
   logic [127:0] wq_data = '0;
   logic [15:0]  wq_mask = '0;
   logic [6:0]   wq_level;
   logic         wq_full, wq_empty, wq_starved;
   logic         rq_pop = 1'b0;
   logic [127:0] rq_data;
   logic [6:0]   rq_level;
   logic         rq_full, rq_empty, rq_lost;

   int total = 0;
   int fails = 0;

   always #5 clk = ~clk;

   uport_ram #(.CAL_CYCLES(CAL), .MEM_WORDS(MW), .CMD_DEPTH(CD)) u_dut (
      .clk(clk), .rst(rst), .init_done(init_done),
      .cq_push(cq_push), .cq_op(cq_op), .cq_len(cq_len), .cq_addr(cq_addr),
      .cq_empty(cq_empty), .cq_full(cq_full),
      .wq_push(wq_push), .wq_data(wq_data), .wq_mask(wq_mask),
      .wq_level(wq_level), .wq_full(wq_full), .wq_empty(wq_empty),
      .wq_starved(wq_starved),
      .rq_pop(rq_pop), .rq_data(rq_data), .rq_level(rq_level),
      .rq_full(rq_full), .rq_empty(rq_empty), .rq_lost(rq_lost)
   );

   task automatic chk(input bit ok, input string tag,
                      input logic [127:0] act, input logic [127:0] exp);
      total++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [127:0] pat(input int i);
      return {32'(i), 32'hFACE0000 + 32'(i), ~32'(i), 32'h13570000 ^ 32'(i)};
   endfunction

   // ---------------- behavioural reference model ----------------
   typedef struct packed {
      logic [2:0]  op;
      logic [5:0]  len;
      logic [29:0] addr;
   } mcmd_t;

   mcmd_t        cq[$];
   logic [143:0] wq[$];
   logic [127:0] rq[$];
   logic [127:0] mmem [MW];
   int           m_state = 0;
   int           m_left = 0;
   int           m_ptr = 0;
   int           m_cal = 0;
   bit           m_starved = 0;
   bit           m_lost = 0;
   int           cn, wn, rn;
   bit           cal_ok, u_cmd, u_wr, u_rd, e_push;
   logic [127:0] e_word;
   logic [143:0] w;
   mcmd_t        hc;

   always @(posedge clk) begin
      if (rst) begin
         cq.delete(); wq.delete(); rq.delete();
         m_state = 0; m_left = 0; m_ptr = 0; m_cal = 0;
         m_starved = 0; m_lost = 0;
      end else begin
         cn = cq.size(); wn = wq.size(); rn = rq.size();
         cal_ok = (m_cal == CAL);
         u_cmd  = cq_push && (cn < CD) && cal_ok;
         u_wr   = wq_push && (wn < FD);
         u_rd   = rq_pop && (rn > 0);
         e_push = 0;
         if (m_state == 0) begin
            if (cn > 0 && (cq[0].op != 3'b001 || (FD - rn) >= int'(cq[0].len) + 1)) begin
               hc = cq.pop_front();
               m_ptr  = int'((hc.addr >> 4) % MW);
               m_left = int'(hc.len);
               if (hc.op == 3'b000) m_state = 1;
               else if (hc.op == 3'b001) m_state = 2;
            end
         end else begin
            if (m_state == 1) begin
               if (wn > 0) begin
                  w = wq.pop_front();
                  for (int b = 0; b < 16; b++)
                     if (!w[128 + b]) mmem[m_ptr][b*8 +: 8] = w[b*8 +: 8];
               end else m_starved = 1;
            end else begin
               if (rn < FD) begin
                  e_push = 1;
                  e_word = mmem[m_ptr];
               end else m_lost = 1;
            end
            m_ptr = (m_ptr + 1) % MW;
            if (m_left == 0) m_state = 0;
            else m_left--;
         end
         if (u_cmd) cq.push_back({cq_op, cq_len, cq_addr});
         if (u_wr)  wq.push_back({wq_mask, wq_data});
         if (u_rd)  void'(rq.pop_front());
         if (e_push) rq.push_back(e_word);
         if (!cal_ok) m_cal++;
      end
   end

   // compare every output with the model on every clock
   always @(negedge clk) begin
      if (!rst) begin
         chk(init_done == (m_cal == CAL), "R1 init_done", 128'(init_done), 128'(m_cal == CAL));
         chk(cq_empty == (cq.size() == 0), "R3 cq_empty", 128'(cq_empty), 128'(cq.size() == 0));
         chk(cq_full == (cq.size() == CD), "R3 cq_full", 128'(cq_full), 128'(cq.size() == CD));
         chk(wq_level == 7'(wq.size()), "R4 wq_level", 128'(wq_level), 128'(wq.size()));
         chk(wq_full == (wq.size() == FD), "R4 wq_full", 128'(wq_full), 128'(wq.size() == FD));
         chk(wq_empty == (wq.size() == 0), "R4 wq_empty", 128'(wq_empty), 128'(wq.size() == 0));
         chk(rq_level == 7'(rq.size()), "R7 rq_level", 128'(rq_level), 128'(rq.size()));
         chk(rq_empty == (rq.size() == 0), "R7 rq_empty", 128'(rq_empty), 128'(rq.size() == 0));
         chk(rq_full == (rq.size() == FD), "R7 rq_full", 128'(rq_full), 128'(rq.size() == FD));
         if (rq.size() > 0)
            chk(rq_data == rq[0], "R7 rq_data", rq_data, rq[0]);
         chk(wq_starved == m_starved, "R9 wq_starved", 128'(wq_starved), 128'(m_starved));
         chk(rq_lost == m_lost, "R8 rq_lost", 128'(rq_lost), 128'(m_lost));
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic push_word(input logic [127:0] d, input logic [15:0] m);
      wq_push = 1'b1; wq_data = d; wq_mask = m;
      @(negedge clk);
      wq_push = 1'b0;
   endtask

   task automatic issue(input logic [2:0] op, input logic [5:0] len, input logic [29:0] a);
      cq_push = 1'b1; cq_op = op; cq_len = len; cq_addr = a;
      @(negedge clk);
      cq_push = 1'b0;
   endtask

   task automatic settle();
      repeat (80) @(negedge clk);
   endtask

   task automatic pop_chk(input logic [127:0] exp, input string tag);
      chk(!rq_empty, {tag, " word present"}, 128'(rq_empty), 128'(0));
      chk(rq_data == exp, tag, rq_data, exp);
      rq_pop = 1'b1;
      @(negedge clk);
      rq_pop = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      total++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

   initial begin
      int popped;
      logic [127:0] dm;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(init_done == 1'b0, "R1 reset init_done", 128'(init_done), 0);
      chk(cq_empty && wq_empty && rq_empty, "R1 reset empties", 128'({cq_empty, wq_empty, rq_empty}), 128'(7));
      chk(wq_level == 0 && rq_level == 0, "R1 reset levels", 128'({wq_level, rq_level}), 0);
      chk(!wq_starved && !rq_lost, "R1 reset flags", 128'({wq_starved, rq_lost}), 0);

      // R2: push commands during the start-up window
      rst = 1'b0;
      cq_push = 1'b1; cq_op = 3'b000; cq_len = 6'd0; cq_addr = '0;
      for (int k = 1; k <= CAL + 1; k++) begin
         @(negedge clk);
         chk(init_done == (k >= CAL), "R1 init_done timing", 128'(init_done), 128'(k >= CAL));
         chk(cq_empty == 1'b1, "R2 early command dropped", 128'(cq_empty), 128'(1));
         if (k == CAL - 1) cq_push = 1'b0;
      end

      // fill the array: words 0..15
      for (int i = 0; i < 16; i++) push_word(pat(i), 16'h0000);
      issue(3'b000, 6'd15, 30'h0);
      settle();

      // R5 read two words, low address bits ignored; R10 order
      issue(3'b001, 6'd1, 30'h2F);
      settle();
      pop_chk(pat(2), "R5 read word 2");
      pop_chk(pat(3), "R10 read word 3 in order");

      // R6 masked write to word 5
      dm = 128'hDEAD_BEEF_0123_4567_89AB_CDEF_F0E1_D2C3;
      push_word(dm, 16'h00FF);
      issue(3'b000, 6'd0, 30'h50);
      settle();
      issue(3'b001, 6'd0, 30'h50);
      settle();
      pop_chk({dm[127:64], pat(5)[63:0]}, "R6 masked bytes kept");

      // R5 wrap: words 14,15,0,1
      for (int k = 0; k < 4; k++) push_word(pat(100 + k), 16'h0000);
      issue(3'b000, 6'd3, 30'hE0);
      settle();
      issue(3'b001, 6'd2, 30'hF0);
      settle();
      pop_chk(pat(101), "R5 wrap word 15");
      pop_chk(pat(102), "R5 wrap word 0");
      pop_chk(pat(103), "R5 wrap word 1");

      // R11 unknown opcode is discarded
      push_word(pat(200), 16'h0000);
      issue(3'b010, 6'd0, 30'h0);
      settle();
      chk(wq_level == 7'd1, "R11 no write data consumed", 128'(wq_level), 128'(1));
      chk(cq_empty == 1'b1, "R11 command removed", 128'(cq_empty), 128'(1));
      issue(3'b001, 6'd0, 30'h0);
      settle();
      pop_chk(pat(102), "R11 word 0 unchanged");
      chk(wq_starved == 1'b0, "R9 no starvation yet", 128'(wq_starved), 0);

      // R9 two-beat write with one word available
      issue(3'b000, 6'd1, 30'h80);
      settle();
      chk(wq_starved == 1'b1, "R9 starvation flagged", 128'(wq_starved), 128'(1));
      issue(3'b001, 6'd1, 30'h80);
      settle();
      pop_chk(pat(200), "R9 first beat written");
      pop_chk(pat(9), "R9 starved beat left word unchanged");

      // R8 read held for room; R3 command queue fills behind it
      issue(3'b001, 6'd62, 30'h0);
      settle();
      chk(rq_level == 7'd63, "R8 return queue at 63", 128'(rq_level), 128'(63));
      issue(3'b001, 6'd1, 30'h0);
      repeat (5) @(negedge clk);
      chk(rq_level == 7'd63, "R8 read held without room", 128'(rq_level), 128'(63));
      chk(cq_empty == 1'b0, "R8 held read still queued", 128'(cq_empty), 0);
      cq_push = 1'b1; cq_op = 3'b001; cq_len = 6'd0; cq_addr = 30'h10;
      repeat (4) @(negedge clk);
      cq_push = 1'b0;
      chk(cq_full == 1'b1, "R3 command queue full", 128'(cq_full), 128'(1));
      popped = 0;
      rq_pop = 1'b1;
      repeat (120) begin
         if (!rq_empty) popped++;
         @(negedge clk);
      end
      rq_pop = 1'b0;
      chk(popped == 68, "R3 push while full dropped", 128'(popped), 128'(68));
      chk(rq_lost == 1'b0, "R8 no lost words", 128'(rq_lost), 0);
      chk(cq_empty == 1'b1, "R10 all commands done", 128'(cq_empty), 128'(1));

      // R4 write queue full, extra push ignored
      for (int i = 0; i < 65; i++) push_word(pat(300 + i), 16'h0000);
      chk(wq_full == 1'b1, "R4 write queue full", 128'(wq_full), 128'(1));
      chk(wq_level == 7'd64, "R4 extra push ignored", 128'(wq_level), 128'(64));
      issue(3'b000, 6'd63, 30'h0);
      settle();
      chk(wq_empty == 1'b1, "R4 drained by 64-beat write", 128'(wq_empty), 128'(1));
      issue(3'b001, 6'd0, 30'h0);
      settle();
      pop_chk(pat(348), "R5 last wrap of word 0");
      chk(wq_starved == 1'b1, "R9 flag still sticky", 128'(wq_starved), 128'(1));

      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

endmodule